// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

The block turns a 32-bit I/O virtual address into a physical address by reading descriptors from a two-level translation table held in memory. A client hands it one address at a time. The walker reads the first-level descriptor through a request/response memory read port. Depending on the two type bits of that descriptor, the walk either ends at once with a 1 MiB mapping or goes on to a second read from a second-level table. It returns the physical address, a page-size code and a fault indication. The result stays on the outputs until the client acknowledges it.

Three mapping granules exist. A first-level entry can map 1 MiB directly. It can also point to a 256-entry second-level table, whose entries map either 4 KiB pages or 64 KiB pages. A 64 KiB page is written into the table as sixteen identical neighbouring entries. Faults are classed by the level that raised them. A descriptor that decodes as invalid gives a translation fault. An error response on the memory port gives a bus-error fault. In both cases the offending virtual address is reported.

Top module: `iova_walker`

## Requirements
- R1: `req_ready_o` is high exactly when no walk is in progress and no result is pending. A request is taken on a cycle where `req_valid_i` and `req_ready_o` are both high. `res_valid_o` and every result output stay unchanged until the cycle `res_ack_i` is high, and `res_valid_o` is low on the next cycle.
- R2: The first read of a walk targets `tbl_base_i + 4*VA[31:20]`, using the table base sampled when the request is taken.
- R3: A first-level descriptor with bits[1:0]=2'b10 ends the walk after one read with `res_pa_o = {desc[31:20], VA[19:0]}` and `res_size_o = 2`.
- R4: A first-level descriptor with bits[1:0]=2'b01 causes a second read at `(desc & 32'hFFFFFC00) | (VA[19:12] << 2)`. Descriptor bits [9:0] have no effect on that address.
- R5: A second-level descriptor with bit 1 set (2'b10 or 2'b11) gives `res_pa_o = {desc[31:12], VA[11:0]}` and `res_size_o = 0`.
- R6: A second-level descriptor with bits[1:0]=2'b01 gives `res_pa_o = {desc[31:16], VA[15:0]}` and `res_size_o = 1`. Each of the sixteen replicated entries of a large page resolves to the same frame.
- R7: A first-level descriptor with bits[1:0] equal to 2'b00 or 2'b11 raises `res_fault_o` with `res_fault_lvl_o = 0` and `res_buserr_o = 0`, and no second read is made.
- R8: A second-level descriptor with bits[1:0]=2'b00 raises `res_fault_o` with `res_fault_lvl_o = 1` and `res_buserr_o = 0`.
- R9: An error response to either read ends the walk with `res_fault_o = 1` and `res_buserr_o = 1`. `res_fault_lvl_o` is 0 for the first read and 1 for the second, and no later read is issued.
- R10: On any fault, `res_fault_va_o` holds the requested VA and `res_pa_o` is 0. With no fault, `res_fault_va_o` is 0.
- R11: A walk issues at most two reads. A read request keeps `mem_rd_valid_o` high with a stable address until `mem_rd_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base_i | input | 32 | Byte address of the first-level table |
| req_valid_i | input | 1 | Translation request present |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| mem_rd_valid_o | output | 1 | Descriptor read request |
| mem_rd_addr_o | output | 32 | Descriptor byte address |
| mem_rd_ready_i | input | 1 | Memory accepts the read request |
| mem_rsp_valid_i | input | 1 | Read response present |
| mem_rsp_data_i | input | 32 | Descriptor word returned |
| mem_rsp_err_i | input | 1 | Read response carries an error |
| res_valid_o | output | 1 | Result available |
| res_ack_i | input | 1 | Client consumes the result |
| res_pa_o | output | 32 | Translated physical address |
| res_size_o | output | 2 | 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB |
| res_fault_o | output | 1 | Walk ended in a fault |
| res_buserr_o | output | 1 | Fault came from an error response |
| res_fault_lvl_o | output | 1 | Level of the fault: 0 first, 1 second |
| res_fault_va_o | output | 32 | VA that faulted |

## Verification
The bench targets the two type-bit encodings, which differ by level. An RTL that swapped them would report 2'b11 at the first level as a mapping instead of a fault, or treat 2'b11 at the second level as a fault instead of a small page. It fills a second-level pointer's low ten bits with junk, so a missing 0xFFFFFC00 mask sends the second read to the wrong word and returns the wrong frame. It probes the first, a middle and the last replica of a large page, where the wrong offset split shows up at once. Error responses at each level, slow memory handshakes and a held-off acknowledge catch a walker that keeps reading after an error, drops a read request before it is accepted, or lets its result drift before the client takes it.

// File: rtl/iovw_pkg.sv
package iovw_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_L1_RD,
        WS_L1_WT,
        WS_L2_RD,
        WS_L2_WT,
        WS_DONE
    } walk_state_e;

    typedef enum logic [2:0] {
        DK_FAULT,
        DK_TABLE,
        DK_SECT,
        DK_LARGE,
        DK_SMALL
    } desc_kind_e;

    localparam logic [1:0] PS_SMALL = 2'd0;
    localparam logic [1:0] PS_LARGE = 2'd1;
    localparam logic [1:0] PS_SECT  = 2'd2;

endpackage

// File: rtl/iovw_desc_decode.sv
module iovw_desc_decode
    import iovw_pkg::*;
#(
    parameter int  DW     = 32,
    parameter bit  SECOND = 1'b0
) (
    input  logic [DW-1:0] desc_i,
    output desc_kind_e    kind_o
);
    generate
        if (SECOND) begin : g_lvl2
            // bit1 alone marks a small page; 01 is a large page; 00 faults
            always_comb begin
                if (desc_i[1])      kind_o = DK_SMALL;
                else if (desc_i[0]) kind_o = DK_LARGE;
                else                kind_o = DK_FAULT;
            end
        end else begin : g_lvl1
            // 10 direct 1 MiB map, 01 table pointer, 00/11 invalid
            always_comb begin
                case (desc_i[1:0])
                    2'b10:   kind_o = DK_SECT;
                    2'b01:   kind_o = DK_TABLE;
                    default: kind_o = DK_FAULT;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/iovw_addr_merge.sv
module iovw_addr_merge
    import iovw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SPAGE_OFF = 12,
    parameter int LPAGE_OFF = 16,
    parameter int SECT_OFF  = 20
) (
    input  logic [AW-1:0] desc_i,
    input  logic [AW-1:0] va_i,
    input  desc_kind_e    kind_i,
    output logic [AW-1:0] pa_o,
    output logic [1:0]    size_o
);
    localparam logic [AW-1:0] ONES   = {AW{1'b1}};
    localparam logic [AW-1:0] SECT_M = ONES << SECT_OFF;
    localparam logic [AW-1:0] LPG_M  = ONES << LPAGE_OFF;
    localparam logic [AW-1:0] SPG_M  = ONES << SPAGE_OFF;

    logic [AW-1:0] frame_m;

    always_comb begin
        case (kind_i)
            DK_SECT:  begin frame_m = SECT_M; size_o = PS_SECT;  end
            DK_LARGE: begin frame_m = LPG_M;  size_o = PS_LARGE; end
            default:  begin frame_m = SPG_M;  size_o = PS_SMALL; end
        endcase
        pa_o = (desc_i & frame_m) | (va_i & ~frame_m);
    end
endmodule

// File: rtl/iova_walker.sv
module iova_walker
    import iovw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int L1_IDX_W  = 12,
    parameter int L2_IDX_W  = 8,
    parameter int SPAGE_OFF = 12,
    parameter int LPAGE_OFF = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] tbl_base_i,
    input  logic          req_valid_i,
    input  logic [AW-1:0] req_va_i,
    output logic          req_ready_o,
    output logic          mem_rd_valid_o,
    output logic [AW-1:0] mem_rd_addr_o,
    input  logic          mem_rd_ready_i,
    input  logic          mem_rsp_valid_i,
    input  logic [AW-1:0] mem_rsp_data_i,
    input  logic          mem_rsp_err_i,
    output logic          res_valid_o,
    input  logic          res_ack_i,
    output logic [AW-1:0] res_pa_o,
    output logic [1:0]    res_size_o,
    output logic          res_fault_o,
    output logic          res_buserr_o,
    output logic          res_fault_lvl_o,
    output logic [AW-1:0] res_fault_va_o
);
    localparam int SECT_OFF = SPAGE_OFF + L2_IDX_W;
    localparam int L2_ALIGN = L2_IDX_W + 2;
    localparam int IDX_PAD  = AW - L1_IDX_W - 2;

    typedef struct packed {
        walk_state_e   st;
        logic [AW-1:0] va;
        logic [AW-1:0] rd_addr;
        logic [AW-1:0] pa;
        logic [1:0]    size;
        logic          fault;
        logic          buserr;
        logic          flvl;
        logic [1:0]    rd_cnt;
    } walk_regs_t;

    walk_regs_t q, d;

    desc_kind_e    l1_kind, l2_kind, mrg_kind;
    logic [AW-1:0] l1_addr, l2_addr, mrg_pa;
    logic [1:0]    mrg_size;
    logic          rd_hs;

    iovw_desc_decode #(.DW(AW), .SECOND(1'b0)) u_dec_l1 (
        .desc_i (mem_rsp_data_i),
        .kind_o (l1_kind)
    );

    iovw_desc_decode #(.DW(AW), .SECOND(1'b1)) u_dec_l2 (
        .desc_i (mem_rsp_data_i),
        .kind_o (l2_kind)
    );

    assign mrg_kind = (q.st == WS_L1_WT) ? l1_kind : l2_kind;

    iovw_addr_merge #(
        .AW(AW), .SPAGE_OFF(SPAGE_OFF), .LPAGE_OFF(LPAGE_OFF), .SECT_OFF(SECT_OFF)
    ) u_merge (
        .desc_i (mem_rsp_data_i),
        .va_i   (q.va),
        .kind_i (mrg_kind),
        .pa_o   (mrg_pa),
        .size_o (mrg_size)
    );

    // word index scaled to bytes, added to the sampled base
    assign l1_addr = tbl_base_i + {{IDX_PAD{1'b0}}, req_va_i[AW-1 -: L1_IDX_W], 2'b00};
    // second-level base is aligned to its table size, so index fills the low bits
    assign l2_addr = {mem_rsp_data_i[AW-1:L2_ALIGN], q.va[SECT_OFF-1:SPAGE_OFF], 2'b00};

    assign rd_hs = mem_rd_valid_o && mem_rd_ready_i;

    always_comb begin
        d = q;
        case (q.st)
            WS_IDLE: begin
                if (req_valid_i) begin
                    d.st      = WS_L1_RD;
                    d.va      = req_va_i;
                    d.rd_addr = l1_addr;
                    d.pa      = '0;
                    d.size    = PS_SMALL;
                    d.fault   = 1'b0;
                    d.buserr  = 1'b0;
                    d.flvl    = 1'b0;
                    d.rd_cnt  = '0;
                end
            end
            WS_L1_RD, WS_L2_RD: begin
                if (rd_hs) begin
                    d.st     = (q.st == WS_L1_RD) ? WS_L1_WT : WS_L2_WT;
                    d.rd_cnt = q.rd_cnt + 2'd1;
                end
            end
            WS_L1_WT: begin
                if (mem_rsp_valid_i) begin
                    d.st = WS_DONE;
                    if (mem_rsp_err_i) begin
                        d.fault  = 1'b1;
                        d.buserr = 1'b1;
                    end else if (l1_kind == DK_SECT) begin
                        d.pa   = mrg_pa;
                        d.size = mrg_size;
                    end else if (l1_kind == DK_TABLE) begin
                        d.st      = WS_L2_RD;
                        d.rd_addr = l2_addr;
                    end else begin
                        d.fault = 1'b1;
                    end
                end
            end
            WS_L2_WT: begin
                if (mem_rsp_valid_i) begin
                    d.st   = WS_DONE;
                    d.flvl = 1'b1;
                    if (mem_rsp_err_i) begin
                        d.fault  = 1'b1;
                        d.buserr = 1'b1;
                    end else if (l2_kind == DK_FAULT) begin
                        d.fault = 1'b1;
                    end else begin
                        d.pa   = mrg_pa;
                        d.size = mrg_size;
                    end
                end
            end
            WS_DONE: begin
                if (res_ack_i) d.st = WS_IDLE;
            end
            default: d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: WS_IDLE, size: PS_SMALL, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready_o     = (q.st == WS_IDLE);
    assign mem_rd_valid_o  = (q.st == WS_L1_RD) || (q.st == WS_L2_RD);
    assign mem_rd_addr_o   = q.rd_addr;
    assign res_valid_o     = (q.st == WS_DONE);
    assign res_pa_o        = q.pa;
    assign res_size_o      = q.size;
    assign res_fault_o     = q.fault;
    assign res_buserr_o    = q.buserr;
    assign res_fault_lvl_o = q.flvl;
    assign res_fault_va_o  = q.fault ? q.va : '0;

    // result is frozen until the client takes it
    assert_res_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ack_i) |=> (res_valid_o && $stable(res_pa_o)
            && $stable(res_fault_o) && $stable(res_size_o) && $stable(res_fault_va_o)));

    // ack ends the result phase
    assert_ack_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_ack_i) |=> (!res_valid_o && req_ready_o));

    // idle excludes every other activity
    assert_idle_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (!res_valid_o && !mem_rd_valid_o));

    // read request held steady until accepted
    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid_o && !mem_rd_ready_i) |=> (mem_rd_valid_o && $stable(mem_rd_addr_o)));

    // never more than two descriptor reads per walk
    assert_two_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rd_cnt <= 2'd2));

    // a section completes after exactly one read
    assert_sect_one_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_fault_o && res_size_o == PS_SECT) |-> (q.rd_cnt == 2'd1));

    // bus errors are always reported as faults
    assert_buserr_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_buserr_o) |-> res_fault_o);

    // second-level faults only after two reads
    assert_l2_fault_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_fault_o && res_fault_lvl_o) |-> (q.rd_cnt == 2'd2));

endmodule

// File: tb/tb_iova_walker.sv
`timescale 1ns/1ps
module tb_iova_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tbl_base_i = 32'h0010_0000;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_va_i = '0;
    logic        req_ready_o;
    logic        mem_rd_valid_o;
    logic [31:0] mem_rd_addr_o;
    logic        mem_rd_ready_i = 1'b0;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic        mem_rsp_err_i = 1'b0;
    logic        res_valid_o;
    logic        res_ack_i = 1'b0;
    logic [31:0] res_pa_o;
    logic [1:0]  res_size_o;
    logic        res_fault_o, res_buserr_o, res_fault_lvl_o;
    logic [31:0] res_fault_va_o;

    always #4 clk = ~clk;

    iova_walker dut (.*);

    integer n_chk = 0, n_fail = 0, cyc = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    integer lat = 0;
    bit     stall = 1'b0;
    bit     busy = 1'b0;
    integer n_reads = 0;
    bit     pend = 1'b0;
    integer pcnt = 0;
    logic [31:0] paddr = '0;

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // memory responder: decides ready at negedge, answers after lat cycles
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            mem_rsp_err_i   = 1'b0;
            if (pend) begin
                if (pcnt == 0) begin
                    mem_rsp_valid_i = 1'b1;
                    mem_rsp_data_i  = rd(paddr);
                    mem_rsp_err_i   = (paddr == err_addr);
                    pend = 1'b0;
                end else pcnt--;
            end
            mem_rd_ready_i = stall ? ((cyc % 3) != 0) : 1'b1;
            if (mem_rd_valid_o && mem_rd_ready_i && !pend) begin
                pend = 1'b1; pcnt = lat; paddr = mem_rd_addr_o; n_reads++;
            end
        end
    end

    // per-cycle comparison of idle state against the model
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk); #2;
            check(req_ready_o == !busy, "R1 ready vs model", {31'b0, req_ready_o}, {31'b0, !busy});
        end
    end

    task automatic walk(input logic [31:0] va, input integer ack_dly);
        logic [31:0] l1a, d1, l2a, d2, e_pa, e_fva;
        logic [1:0]  e_sz;
        bit e_f, e_be, e_lv;
        integer e_rd, guard;
        logic [31:0] pa_hold;
        e_pa = 0; e_sz = 0; e_f = 0; e_be = 0; e_lv = 0; e_rd = 1;
        l1a = tbl_base_i + {18'b0, va[31:20], 2'b00};
        d1 = rd(l1a);
        if (l1a == err_addr) begin e_f = 1; e_be = 1; end
        else if (d1[1:0] == 2'b10) begin e_pa = {d1[31:20], va[19:0]}; e_sz = 2; end
        else if (d1[1:0] == 2'b01) begin
            e_rd = 2; e_lv = 1;
            l2a = (d1 & 32'hFFFF_FC00) | {22'b0, va[19:12], 2'b00};
            d2 = rd(l2a);
            if (l2a == err_addr) begin e_f = 1; e_be = 1; end
            else if (d2[1]) begin e_pa = {d2[31:12], va[11:0]}; e_sz = 0; e_lv = 0; end
            else if (d2[0]) begin e_pa = {d2[31:16], va[15:0]}; e_sz = 1; e_lv = 0; end
            else e_f = 1;
        end else e_f = 1;
        e_fva = e_f ? va : 32'h0;

        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_valid_i = 1'b1; req_va_i = va; busy = 1'b1; n_reads = 0;
        @(negedge clk);
        req_valid_i = 1'b0;
        guard = 0;
        while (!res_valid_o && guard < 200) begin @(negedge clk); guard++; end
        check(res_valid_o, "R1 result appears", {31'b0, res_valid_o}, 32'h1);
        check(res_fault_o == e_f, e_f ? (e_lv ? "R8 fault flag" : "R7 fault flag") : "R3 R5 R6 no fault",
              {31'b0, res_fault_o}, {31'b0, e_f});
        check(res_buserr_o == e_be, "R9 bus error flag", {31'b0, res_buserr_o}, {31'b0, e_be});
        if (e_f) check(res_fault_lvl_o == e_lv, "R7 R8 R9 fault level", {31'b0, res_fault_lvl_o}, {31'b0, e_lv});
        check(res_pa_o == e_pa, "R2 R3 R4 R5 R6 physical address", res_pa_o, e_pa);
        if (!e_f) check(res_size_o == e_sz, "R3 R5 R6 size code", {30'b0, res_size_o}, {30'b0, e_sz});
        check(res_fault_va_o == e_fva, "R10 fault VA", res_fault_va_o, e_fva);
        check(n_reads == e_rd, "R11 read count", n_reads, e_rd);
        pa_hold = res_pa_o;
        for (int i = 0; i < ack_dly; i++) begin
            @(negedge clk);
            check(res_valid_o && res_pa_o == pa_hold, "R1 hold before ack", res_pa_o, pa_hold);
        end
        res_ack_i = 1'b1; busy = 1'b0;
        @(negedge clk);
        res_ack_i = 1'b0;
        check(!res_valid_o, "R1 release after ack", {31'b0, res_valid_o}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // first-level entries at base 0x0010_0000
        mem[32'h0010_0000 + 32'h123*4] = 32'hABC0_0002;
        mem[32'h0010_0000 + 32'hFFF*4] = 32'h5550_0002;
        mem[32'h0010_0000 + 32'h001*4] = 32'h0000_0000;
        mem[32'h0010_0000 + 32'h002*4] = 32'h0000_0003;
        mem[32'h0010_0000 + 32'h010*4] = 32'h0080_07FD;   // pointer with junk low bits
        mem[32'h0080_0400 + 32'h05*4]  = 32'h7000_1002;
        mem[32'h0080_0400 + 32'h06*4]  = 32'h7100_2FFF;
        mem[32'h0080_0400 + 32'h07*4]  = 32'h0000_0000;
        mem[32'h0080_0400 + 32'h08*4]  = 32'h7200_3002;
        for (int i = 32'h20; i < 32'h30; i++) mem[32'h0080_0400 + i*4] = 32'h9123_0001;
        mem[32'h0020_4000 + 32'h123*4] = 32'h3330_0002;

        repeat (3) @(negedge clk);
        check(req_ready_o && !res_valid_o && !mem_rd_valid_o, "R1 reset state",
              {29'b0, req_ready_o, res_valid_o, mem_rd_valid_o}, 32'h4);
        rst_n = 1'b1;

        walk(32'h1234_5678, 0);           // R3 section
        walk(32'hFFFF_FFFC, 0);           // R3 last index
        walk(32'h0010_0000, 0);           // R7 type 00
        walk(32'h0020_0000, 0);           // R7 type 11
        lat = 2; stall = 1'b1;
        walk(32'h0100_5ABC, 0);           // R4 R5 small page 10
        walk(32'h0100_6123, 3);           // R5 small page 11, R1 held ack
        walk(32'h0102_0345, 0);           // R6 first replica
        walk(32'h0102_7ABC, 0);           // R6 middle replica
        walk(32'h0102_FFFF, 0);           // R6 last replica
        walk(32'h0100_7000, 0);           // R8 second-level fault
        lat = 0; stall = 1'b0;
        err_addr = 32'h0010_0000 + 32'h030*4;
        walk(32'h0300_0000, 0);           // R9 error on first read
        err_addr = 32'h0080_0400 + 32'h08*4;
        walk(32'h0100_8000, 2);           // R9 error on second read
        err_addr = 32'hFFFF_FFFF;
        walk(32'h0100_8ABC, 0);           // same entry without error
        tbl_base_i = 32'h0020_4000;
        walk(32'h1234_5678, 0);           // R2 different base

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule